// File: doc/BRIEF.md
# Dataflow Thread Synchronization Unit

This block decides when a thread instance may run, based only on whether its inputs have been produced. A graph table, indexed by thread number, holds each thread's code pointer, its data pointer and up to two consumer thread numbers. A count table holds one outstanding-input count per thread and iteration index. The processor takes runnable-thread descriptors from a ready queue. When a thread has run to completion, the processor pushes a completion record (thread, index, status) into an acknowledge queue.

For every completion record, the update engine reads the finished thread's two consumer slots in order. For each consumer that is not the null thread (number 0), it decrements that consumer's count at the same index. When a count reaches zero, it pushes a descriptor into the ready queue. The descriptor holds the consumer's two pointers and the index. Software loads both tables through a configuration port while the engine is quiet. The engine is a four-state machine:

- ST_IDLE: waits for a record and pops it, then goes to ST_CONS.
- ST_CONS: picks the current consumer slot. A null slot goes to the next slot or back to ST_IDLE. Any other slot goes to ST_DEC.
- ST_DEC: performs the read-modify-write on the count. A count that reaches zero goes to ST_EMIT; otherwise the engine goes to the next slot or to ST_IDLE.
- ST_EMIT: holds the descriptor until the ready queue accepts it, then goes to the next slot or to ST_IDLE.

Top module: `tsu_top`

## Requirements
- R1: After reset the ready queue is empty (rq_valid=0), the acknowledge queue accepts (aq_ready=1), err_zero_dec=0, and every table entry is zero.
- R2: A consumer whose count is 1 becomes ready after one completion of its producer at the same index. The ready entry carries the consumer's code pointer (rq_ifp), its data pointer (rq_dfp) and the completion's index (rq_index).
- R3: Counts are kept per index. A consumer with count N is not made ready before N completions at that index, and completions at other indices leave it untouched.
- R4: A consumer slot holding thread number 0 is skipped, and no count is changed for it. A record whose slots are both 0 produces no ready entry.
- R5: Consumer slot 0 is processed before slot 1. When both reach zero on one completion, slot 0's entry enters the ready queue first.
- R6: While the ready queue is full, the engine holds its pending entry and pops no further acknowledge records. aq_ready falls once the acknowledge queue is full. After the stall clears, every ready entry comes out once, in order.
- R7: Decrementing a count that is already 0 produces no ready entry and sets err_zero_dec. The flag stays at 1 until reset.
- R8: The status field of a completion record has no effect on scheduling.
- R9: Both queues deliver entries in arrival order and obey valid/ready: an entry is transferred only in a cycle where valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gm_we | input | 1 | Write one graph table entry |
| cfg_gm_thread | input | TID_W | Graph entry to write |
| cfg_gm_ifp | input | PTR_W | Code pointer |
| cfg_gm_dfp | input | PTR_W | Data pointer |
| cfg_gm_con0 | input | TID_W | First consumer (0 = none) |
| cfg_gm_con1 | input | TID_W | Second consumer (0 = none) |
| cfg_sm_we | input | 1 | Write one count |
| cfg_sm_thread | input | TID_W | Count thread |
| cfg_sm_index | input | IDX_W | Count index |
| cfg_sm_count | input | CNT_W | Count value |
| aq_valid | input | 1 | Completion record offered |
| aq_ready | output | 1 | Acknowledge queue has room |
| aq_thread | input | TID_W | Completed thread |
| aq_index | input | IDX_W | Completed index |
| aq_status | input | ST_W | Completion status (no effect) |
| rq_valid | output | 1 | Ready entry available |
| rq_ready | input | 1 | Processor takes the entry |
| rq_ifp | output | PTR_W | Ready thread code pointer |
| rq_dfp | output | PTR_W | Ready thread data pointer |
| rq_index | output | IDX_W | Ready thread index |
| err_zero_dec | output | 1 | Sticky: a zero count was decremented |

## Verification
The bench builds the block with eight threads, four indices, 3-bit counts, 8-bit pointers and both queues two entries deep. The shallow queues let a handful of completions fill the ready queue, hold the engine in ST_EMIT and then fill the acknowledge queue, so the stall and no-loss behaviour can be reached directly. With four indices, a single producer can feed independent count instances of one consumer, and the bench uses this to show that each index keeps its own count.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONS,
        ST_DEC,
        ST_EMIT
    } tsu_state_e;
endpackage

// File: rtl/tsu_fifo.sv
module tsu_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign in_ready  = (cnt_q != CW'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign out_data  = mem[rd_q];
    assign do_push   = in_valid && in_ready;
    assign do_pop    = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                mem[wr_q] <= in_data;
                wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
            if (do_push && !do_pop) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (do_pop && !do_push) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R9: occupancy never exceeds depth
    p_fifo_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R9: an offered head entry is held until taken
    p_fifo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/tsu_tables.sv
module tsu_tables #(
    parameter int TID_W = 4,
    parameter int IDX_W = 3,
    parameter int PTR_W = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_gm_we,
    input  logic [TID_W-1:0] cfg_gm_thread,
    input  logic [PTR_W-1:0] cfg_gm_ifp,
    input  logic [PTR_W-1:0] cfg_gm_dfp,
    input  logic [TID_W-1:0] cfg_gm_con0,
    input  logic [TID_W-1:0] cfg_gm_con1,
    input  logic             cfg_sm_we,
    input  logic [TID_W-1:0] cfg_sm_thread,
    input  logic [IDX_W-1:0] cfg_sm_index,
    input  logic [CNT_W-1:0] cfg_sm_count,
    input  logic [TID_W-1:0] prod_thread,
    output logic [TID_W-1:0] prod_con0,
    output logic [TID_W-1:0] prod_con1,
    input  logic [TID_W-1:0] cons_thread,
    output logic [PTR_W-1:0] cons_ifp,
    output logic [PTR_W-1:0] cons_dfp,
    input  logic [IDX_W-1:0] cnt_index,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata
);
    localparam int NT = 1 << TID_W;
    localparam int NI = 1 << IDX_W;

    logic [PTR_W-1:0] ifp_q  [NT];
    logic [PTR_W-1:0] dfp_q  [NT];
    logic [TID_W-1:0] con0_q [NT];
    logic [TID_W-1:0] con1_q [NT];
    logic [CNT_W-1:0] cnt_q  [NT][NI];

    assign prod_con0 = con0_q[prod_thread];
    assign prod_con1 = con1_q[prod_thread];
    assign cons_ifp  = ifp_q[cons_thread];
    assign cons_dfp  = dfp_q[cons_thread];
    assign cnt_rdata = cnt_q[cons_thread][cnt_index];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                ifp_q[t]  <= '0;
                dfp_q[t]  <= '0;
                con0_q[t] <= '0;
                con1_q[t] <= '0;
            end
        end else if (cfg_gm_we) begin
            ifp_q[cfg_gm_thread]  <= cfg_gm_ifp;
            dfp_q[cfg_gm_thread]  <= cfg_gm_dfp;
            con0_q[cfg_gm_thread] <= cfg_gm_con0;
            con1_q[cfg_gm_thread] <= cfg_gm_con1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                for (int i = 0; i < NI; i++) begin
                    cnt_q[t][i] <= '0;
                end
            end
        end else if (cnt_we) begin
            cnt_q[cons_thread][cnt_index] <= cnt_wdata;
        end else if (cfg_sm_we) begin
            cnt_q[cfg_sm_thread][cfg_sm_index] <= cfg_sm_count;
        end
    end
endmodule

// File: rtl/tsu_engine.sv
module tsu_engine
    import tsu_pkg::*;
#(
    parameter int TID_W = 4,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_valid,
    output logic             ack_pop,
    input  logic [TID_W-1:0] ack_thread,
    input  logic [IDX_W-1:0] ack_index,
    output logic [TID_W-1:0] prod_thread,
    input  logic [TID_W-1:0] prod_con0,
    input  logic [TID_W-1:0] prod_con1,
    output logic [TID_W-1:0] cons_thread,
    output logic [IDX_W-1:0] cur_index,
    input  logic [CNT_W-1:0] cnt_rdata,
    output logic             cnt_we,
    output logic [CNT_W-1:0] cnt_wdata,
    output logic             emit_valid,
    input  logic             emit_ready,
    output logic             err_zero_dec
);
    localparam logic [TID_W-1:0] NULL_TID = '0;

    tsu_state_e       state_q, state_d;
    logic [TID_W-1:0] a_thr_q, c_thr_q;
    logic [IDX_W-1:0] a_idx_q;
    logic             slot_q;
    logic             err_q;
    logic [TID_W-1:0] pick;
    tsu_state_e       after_slot;

    assign pick         = slot_q ? prod_con1 : prod_con0;
    assign after_slot   = slot_q ? ST_IDLE : ST_CONS;
    assign prod_thread  = a_thr_q;
    assign cons_thread  = c_thr_q;
    assign cur_index    = a_idx_q;
    assign err_zero_dec = err_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        ack_pop    = 1'b0;
        cnt_we     = 1'b0;
        cnt_wdata  = cnt_rdata - 1'b1;
        emit_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ack_valid) begin
                    ack_pop = 1'b1;
                    state_d = ST_CONS;
                end
            end
            ST_CONS: begin
                state_d = (pick == NULL_TID) ? after_slot : ST_DEC;
            end
            ST_DEC: begin
                if (cnt_rdata == '0) begin
                    state_d = after_slot;
                end else begin
                    cnt_we  = 1'b1;
                    state_d = (cnt_rdata == CNT_W'(1)) ? ST_EMIT : after_slot;
                end
            end
            ST_EMIT: begin
                emit_valid = 1'b1;
                if (emit_ready) state_d = after_slot;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_thr_q <= '0;
            a_idx_q <= '0;
            c_thr_q <= '0;
            slot_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && ack_valid) begin
                a_thr_q <= ack_thread;
                a_idx_q <= ack_index;
                slot_q  <= 1'b0;
            end
            if (state_q != ST_IDLE && state_d == ST_CONS) begin
                slot_q <= 1'b1;
            end
            if (state_q == ST_CONS && pick != NULL_TID) begin
                c_thr_q <= pick;
            end
            if (state_q == ST_DEC && cnt_rdata == '0) begin
                err_q <= 1'b1;
            end
        end
    end

    // R4: a null consumer never reaches the count update
    p_null_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEC) |-> (c_thr_q != NULL_TID));

    // R6: a refused ready entry is held unchanged
    p_emit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT && !emit_ready) |=>
        (state_q == ST_EMIT && $stable(c_thr_q) && $stable(a_idx_q)));

    // R7: the error flag is sticky
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/tsu_top.sv
module tsu_top #(
    parameter int TID_W    = 4,
    parameter int IDX_W    = 3,
    parameter int PTR_W    = 16,
    parameter int CNT_W    = 4,
    parameter int ST_W     = 2,
    parameter int RQ_DEPTH = 8,
    parameter int AQ_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_gm_we,
    input  logic [TID_W-1:0] cfg_gm_thread,
    input  logic [PTR_W-1:0] cfg_gm_ifp,
    input  logic [PTR_W-1:0] cfg_gm_dfp,
    input  logic [TID_W-1:0] cfg_gm_con0,
    input  logic [TID_W-1:0] cfg_gm_con1,
    input  logic             cfg_sm_we,
    input  logic [TID_W-1:0] cfg_sm_thread,
    input  logic [IDX_W-1:0] cfg_sm_index,
    input  logic [CNT_W-1:0] cfg_sm_count,
    input  logic             aq_valid,
    output logic             aq_ready,
    input  logic [TID_W-1:0] aq_thread,
    input  logic [IDX_W-1:0] aq_index,
    input  logic [ST_W-1:0]  aq_status,
    output logic             rq_valid,
    input  logic             rq_ready,
    output logic [PTR_W-1:0] rq_ifp,
    output logic [PTR_W-1:0] rq_dfp,
    output logic [IDX_W-1:0] rq_index,
    output logic             err_zero_dec
);
    localparam int AQ_W = TID_W + IDX_W;
    localparam int RQ_W = 2 * PTR_W + IDX_W;

    logic             ack_valid, ack_pop;
    logic [AQ_W-1:0]  ack_word;
    logic [TID_W-1:0] prod_thread, prod_con0, prod_con1, cons_thread;
    logic [PTR_W-1:0] cons_ifp, cons_dfp;
    logic [IDX_W-1:0] cur_index;
    logic [CNT_W-1:0] cnt_rdata, cnt_wdata;
    logic             cnt_we, emit_valid, emit_ready;
    logic [RQ_W-1:0]  rq_word;

    tsu_fifo #(.W(AQ_W), .DEPTH(AQ_DEPTH)) u_ackq (
        .clk(clk), .rst_n(rst_n),
        .in_valid(aq_valid), .in_ready(aq_ready),
        .in_data({aq_thread, aq_index}),
        .out_valid(ack_valid), .out_ready(ack_pop), .out_data(ack_word)
    );

    tsu_tables #(.TID_W(TID_W), .IDX_W(IDX_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_tables (
        .clk(clk), .rst_n(rst_n),
        .cfg_gm_we(cfg_gm_we), .cfg_gm_thread(cfg_gm_thread),
        .cfg_gm_ifp(cfg_gm_ifp), .cfg_gm_dfp(cfg_gm_dfp),
        .cfg_gm_con0(cfg_gm_con0), .cfg_gm_con1(cfg_gm_con1),
        .cfg_sm_we(cfg_sm_we), .cfg_sm_thread(cfg_sm_thread),
        .cfg_sm_index(cfg_sm_index), .cfg_sm_count(cfg_sm_count),
        .prod_thread(prod_thread), .prod_con0(prod_con0), .prod_con1(prod_con1),
        .cons_thread(cons_thread), .cons_ifp(cons_ifp), .cons_dfp(cons_dfp),
        .cnt_index(cur_index), .cnt_rdata(cnt_rdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata)
    );

    tsu_engine #(.TID_W(TID_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .ack_valid(ack_valid), .ack_pop(ack_pop),
        .ack_thread(ack_word[AQ_W-1:IDX_W]), .ack_index(ack_word[IDX_W-1:0]),
        .prod_thread(prod_thread), .prod_con0(prod_con0), .prod_con1(prod_con1),
        .cons_thread(cons_thread), .cur_index(cur_index),
        .cnt_rdata(cnt_rdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .emit_valid(emit_valid), .emit_ready(emit_ready),
        .err_zero_dec(err_zero_dec)
    );

    tsu_fifo #(.W(RQ_W), .DEPTH(RQ_DEPTH)) u_readyq (
        .clk(clk), .rst_n(rst_n),
        .in_valid(emit_valid), .in_ready(emit_ready),
        .in_data({cons_ifp, cons_dfp, cur_index}),
        .out_valid(rq_valid), .out_ready(rq_ready), .out_data(rq_word)
    );

    assign rq_ifp   = rq_word[RQ_W-1 -: PTR_W];
    assign rq_dfp   = rq_word[IDX_W +: PTR_W];
    assign rq_index = rq_word[IDX_W-1:0];

    // R8: status is accepted with the record but must be a defined value
    p_status_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
        aq_valid |-> !$isunknown(aq_status));
endmodule

// File: tb/tsu_top_tb.sv
`timescale 1ns/1ps
module tsu_top_tb;
    localparam int TID_W = 3, IDX_W = 2, PTR_W = 8, CNT_W = 3, ST_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_gm_we = 0, cfg_sm_we = 0;
    logic [TID_W-1:0] cfg_gm_thread = 0, cfg_gm_con0 = 0, cfg_gm_con1 = 0, cfg_sm_thread = 0;
    logic [PTR_W-1:0] cfg_gm_ifp = 0, cfg_gm_dfp = 0;
    logic [IDX_W-1:0] cfg_sm_index = 0;
    logic [CNT_W-1:0] cfg_sm_count = 0;
    logic aq_valid = 0;
    logic aq_ready;
    logic [TID_W-1:0] aq_thread = 0;
    logic [IDX_W-1:0] aq_index = 0;
    logic [ST_W-1:0]  aq_status = 0;
    logic rq_valid;
    logic rq_ready = 0;
    logic [PTR_W-1:0] rq_ifp, rq_dfp;
    logic [IDX_W-1:0] rq_index;
    logic err_zero_dec;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    logic [PTR_W-1:0] g_ifp, g_dfp;
    logic [IDX_W-1:0] g_idx;
    bit   g_got;

    always #2 clk = ~clk;

    tsu_top #(.TID_W(TID_W), .IDX_W(IDX_W), .PTR_W(PTR_W), .CNT_W(CNT_W),
              .ST_W(ST_W), .RQ_DEPTH(2), .AQ_DEPTH(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_gm_we(cfg_gm_we), .cfg_gm_thread(cfg_gm_thread),
        .cfg_gm_ifp(cfg_gm_ifp), .cfg_gm_dfp(cfg_gm_dfp),
        .cfg_gm_con0(cfg_gm_con0), .cfg_gm_con1(cfg_gm_con1),
        .cfg_sm_we(cfg_sm_we), .cfg_sm_thread(cfg_sm_thread),
        .cfg_sm_index(cfg_sm_index), .cfg_sm_count(cfg_sm_count),
        .aq_valid(aq_valid), .aq_ready(aq_ready), .aq_thread(aq_thread),
        .aq_index(aq_index), .aq_status(aq_status),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_ifp(rq_ifp),
        .rq_dfp(rq_dfp), .rq_index(rq_index), .err_zero_dec(err_zero_dec)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            summary();
        end
    end

    task automatic set_gm(input int t, input int ifp, input int dfp, input int c0, input int c1);
        @(negedge clk);
        cfg_gm_we = 1; cfg_gm_thread = TID_W'(t);
        cfg_gm_ifp = PTR_W'(ifp); cfg_gm_dfp = PTR_W'(dfp);
        cfg_gm_con0 = TID_W'(c0); cfg_gm_con1 = TID_W'(c1);
        @(negedge clk);
        cfg_gm_we = 0;
    endtask

    task automatic set_cnt(input int t, input int i, input int c);
        @(negedge clk);
        cfg_sm_we = 1; cfg_sm_thread = TID_W'(t);
        cfg_sm_index = IDX_W'(i); cfg_sm_count = CNT_W'(c);
        @(negedge clk);
        cfg_sm_we = 0;
    endtask

    task automatic push_ack(input int t, input int i, input int st);
        @(negedge clk);
        aq_valid = 1; aq_thread = TID_W'(t); aq_index = IDX_W'(i); aq_status = ST_W'(st);
        while (!aq_ready) @(negedge clk);
        @(posedge clk);
        #1 aq_valid = 0;
    endtask

    task automatic take_rq(input int limit);
        g_got = 0;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (rq_valid) begin
                g_got = 1; g_ifp = rq_ifp; g_dfp = rq_dfp; g_idx = rq_index;
                rq_ready = 1;
                @(posedge clk);
                #1 rq_ready = 0;
                break;
            end
        end
    endtask

    task automatic expect_entry(input string req, input int ifp, input int dfp, input int idx);
        take_rq(60);
        check(g_got, req, int'(g_got), 1);
        check(g_ifp == PTR_W'(ifp), req, int'(g_ifp), ifp);
        check(g_dfp == PTR_W'(dfp), req, int'(g_dfp), dfp);
        check(g_idx == IDX_W'(idx), req, int'(g_idx), idx);
    endtask

    task automatic expect_none(input string req);
        repeat (20) @(negedge clk);
        check(!rq_valid, req, int'(rq_valid), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!rq_valid, "R1 rq_valid", int'(rq_valid), 0);
        check(aq_ready, "R1 aq_ready", int'(aq_ready), 1);
        check(!err_zero_dec, "R1 err", int'(err_zero_dec), 0);
        push_ack(3, 0, 0);
        expect_none("R1 cleared graph");
    endtask

    task automatic t_single();
        set_gm(1, 8'h10, 8'h11, 2, 0);
        set_gm(2, 8'h20, 8'h21, 0, 0);
        set_gm(3, 8'h30, 8'h31, 0, 0);
        set_gm(6, 8'h60, 8'h61, 0, 0);
        set_cnt(2, 1, 1);
        push_ack(1, 1, 0);
        expect_entry("R2 single", 8'h20, 8'h21, 1);
    endtask

    task automatic t_multi();
        set_gm(4, 8'h40, 8'h41, 3, 0);
        set_cnt(3, 0, 2);
        set_cnt(3, 2, 1);
        push_ack(4, 0, 1);
        expect_none("R3 count two after one");
        push_ack(4, 2, 2);
        expect_entry("R3 other index", 8'h30, 8'h31, 2);
        push_ack(4, 0, 3);
        expect_entry("R3 second completion", 8'h30, 8'h31, 0);
    endtask

    task automatic t_null();
        set_gm(5, 8'h50, 8'h51, 0, 0);
        push_ack(5, 0, 0);
        expect_none("R4 both null");
        set_gm(5, 8'h50, 8'h51, 0, 6);
        set_cnt(6, 0, 1);
        push_ack(5, 0, 0);
        expect_entry("R4 skip slot0", 8'h60, 8'h61, 0);
        check(!err_zero_dec, "R4 no count touched", int'(err_zero_dec), 0);
    endtask

    task automatic t_two();
        set_gm(7, 8'h70, 8'h71, 2, 3);
        set_cnt(2, 3, 1);
        set_cnt(3, 3, 1);
        push_ack(7, 3, 3);
        expect_entry("R5 slot0 first R8", 8'h20, 8'h21, 3);
        expect_entry("R5 slot1 second", 8'h30, 8'h31, 3);
    endtask

    task automatic t_stall();
        for (int i = 0; i < 4; i++) set_cnt(2, i, 1);
        for (int i = 0; i < 4; i++) push_ack(1, i, 0);
        push_ack(0, 0, 0);
        repeat (12) @(negedge clk);
        check(rq_valid, "R6 rq held", int'(rq_valid), 1);
        check(!aq_ready, "R6 aq full", int'(aq_ready), 0);
        for (int i = 0; i < 4; i++) expect_entry("R6 no loss R9 order", 8'h20, 8'h21, i);
        expect_none("R6 no extra");
        check(aq_ready, "R6 aq drained", int'(aq_ready), 1);
    endtask

    task automatic t_err();
        push_ack(4, 1, 0);
        expect_none("R7 no entry");
        check(err_zero_dec, "R7 err set", int'(err_zero_dec), 1);
        set_cnt(2, 0, 1);
        push_ack(1, 0, 0);
        expect_entry("R7 continues", 8'h20, 8'h21, 0);
        check(err_zero_dec, "R7 sticky", int'(err_zero_dec), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_single();
        t_multi();
        t_null();
        t_two();
        t_stall();
        t_err();
        summary();
    end
endmodule